// File: doc/BRIEF.md
# UART transmitter with fractional stop period

This block is the transmit half of one asynchronous serial channel. It runs from the system clock and advances only on a one-cycle enable that pulses sixteen times per bit. An ext1x mode is also provided, where each pulse is one whole bit. A character is written into a one-entry holding register. When the shift stage is free, the character moves into it and goes out on the line. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period whose length is set in sixteenths of a bit.

Each character can wait for a clear-to-send input before it starts. When the channel is switched off, the block can also drop its request-to-send output by itself once everything has left the line. The frame settings (length, parity, stop code, clock mode) are captured when a character enters the shift stage. Changing them during a frame therefore affects only later characters.

Top module: `uart_tx_frac`

## Requirements
- R1: After reset txd is 1, rts is 0 (negated), tx_rdy is 1 and tx_empty is 1. The line stays 1 whenever tx_empty is 1.
- R2: A write (wr_valid) is taken into the holding register only while tx_enable is 1 and tx_rdy is 1. tx_rdy is 0 while the holding register is full. A write made while the register is full, or while tx_enable is 0, is ignored and never appears on the line.
- R3: A frame starts with txd low for one bit time (16 enable pulses). It then sends 5 + char_len data bits, each for one bit time, least significant bit first. The encoding is char_len 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits.
- R4: parity_mode 01 adds an even-parity bit and 10 adds an odd-parity bit. Each parity bit lasts one bit time and is computed over the sent data bits only. Modes 00 and 11 add no parity bit.
- R5: With 6 to 8 data bits the stop period lasts 9 + stop_code pulses for codes 0 to 7, and 17 + stop_code pulses for codes 8 to 15.
- R6: With 5 data bits the stop period lasts 17 + stop_code pulses for every code.
- R7: With ext1x = 1 every bit lasts one pulse. The stop period is one pulse when stop_code bit 3 is 0 and two pulses when it is 1.
- R8: If the holding register is full on the pulse that ends a stop period, the next start bit begins on that same pulse, with no idle gap.
- R9: With cts_en = 1, a character starts only on a pulse where cts = 1. Until then txd stays high and the character stays in the holding register.
- R10: Once a character has started, a change on cts does not alter it.
- R11: tx_empty is 1 exactly when the holding register and the shift stage are both empty. tx_empty = 1 implies tx_rdy = 1.
- R12: A pulse on rts_set makes rts 1. If rts_en = 1, cts_en = 0 and tx_enable = 0, rts returns to 0 on the 16th enable pulse (the 1st in ext1x mode) counted after tx_empty became 1.
- R13: When rts_en = 0, or when rts_en and cts_en are both 1, the transmitter never clears rts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Bit-rate enable, 16 pulses per bit (1 per bit when ext1x) |
| tx_enable | input | 1 | Transmitter on; gates new writes and the RTS countdown |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| char_len | input | 2 | Data bits minus 5 |
| parity_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| stop_code | input | 4 | Stop period code |
| ext1x | input | 1 | Enable pulses are at bit rate |
| cts_en | input | 1 | Gate each character start on cts |
| cts | input | 1 | Clear-to-send, 1 = asserted |
| rts_en | input | 1 | Automatic RTS negation enable |
| rts_set | input | 1 | Pulse that asserts rts |
| txd | output | 1 | Serial line, idles high |
| rts | output | 1 | Request-to-send, 1 = asserted |
| tx_rdy | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
Two events can fall on the same enable pulse: the last pulse of one stop period, and the hand-over of a waiting character into the shift stage. To provoke this, the bench writes a second character as soon as the first has left the holding register. It then checks two things. The combined busy span must equal twice the single-frame length plus one pulse, with no idle slot between the frames. A third write made while the register is full must leave no trace on the line. The bench also lets the RTS countdown run against an idle, disabled transmitter and checks the pulse on which rts falls.

// File: rtl/uart_tx_frac_pkg.sv
package uart_tx_frac_pkg;

  localparam int unsigned OVS    = 16;
  localparam int unsigned TCNT_W = $clog2(2 * OVS + 1);

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_e;

  // enable pulses per bit
  function automatic logic [TCNT_W-1:0] bit_ticks(input logic ext1x);
    return ext1x ? TCNT_W'(1) : TCNT_W'(OVS);
  endfunction

  // stop period in enable pulses
  function automatic logic [TCNT_W-1:0] stop_ticks(input logic [3:0] code,
                                                    input logic       five,
                                                    input logic       ext1x);
    if (ext1x)
      return code[3] ? TCNT_W'(2) : TCNT_W'(1);
    else if (five || code[3])
      return TCNT_W'(17) + TCNT_W'(code);
    else
      return TCNT_W'(9) + TCNT_W'(code);
  endfunction

endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic accept;
  assign accept = wr_valid && tx_enable && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (accept) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import uart_tx_frac_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MIN_BITS = 5,
  parameter int unsigned LEN_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [LEN_W-1:0]  char_len,
  input  logic [1:0]        parity_mode,
  input  logic [3:0]        stop_code,
  input  logic              ext1x,
  input  logic              cts_en,
  input  logic              cts,
  output logic              take,
  output logic              idle,
  output logic              txd
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  // parity over bits 0..last_idx
  function automatic logic par_of(input logic [DATA_W-1:0] d,
                                  input logic [IDX_W-1:0]  last_idx,
                                  input logic [1:0]        mode);
    logic p;
    p = 1'b0;
    for (int i = 0; i < int'(DATA_W); i++)
      if (i <= int'(last_idx)) p = p ^ d[i];
    return (mode == 2'b10) ? ~p : p;
  endfunction

  phase_e              phase_q;
  logic [TCNT_W-1:0]   cnt_q, bt_q, stop_q, seg_len;
  logic [DATA_W-1:0]   sh_q;
  logic [IDX_W-1:0]    idx_q, last_q, last_next;
  logic                par_on_q, par_q;
  logic                gate, seg_end, slot_free;

  assign last_next = IDX_W'(MIN_BITS - 1) + IDX_W'(char_len);
  assign seg_len   = (phase_q == PH_STOP) ? stop_q : bt_q;
  assign seg_end   = tick16 && (phase_q != PH_IDLE) && (cnt_q == seg_len - 1'b1);
  assign gate      = !cts_en || cts;
  assign slot_free = (phase_q == PH_IDLE) || ((phase_q == PH_STOP) && seg_end);
  assign take      = tick16 && hold_full && gate && slot_free;
  assign idle      = (phase_q == PH_IDLE);

  always_comb begin
    unique case (phase_q)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = sh_q[0];
      PH_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      bt_q     <= TCNT_W'(OVS);
      stop_q   <= TCNT_W'(OVS);
      sh_q     <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      par_on_q <= 1'b0;
      par_q    <= 1'b0;
    end else if (take) begin
      phase_q  <= PH_START;
      cnt_q    <= '0;
      sh_q     <= hold_data;
      idx_q    <= '0;
      last_q   <= last_next;
      bt_q     <= bit_ticks(ext1x);
      stop_q   <= stop_ticks(stop_code, char_len == '0, ext1x);
      par_on_q <= (parity_mode == 2'b01) || (parity_mode == 2'b10);
      par_q    <= par_of(hold_data, last_next, parity_mode);
    end else if (tick16 && phase_q != PH_IDLE) begin
      if (seg_end) begin
        cnt_q <= '0;
        unique case (phase_q)
          PH_START: phase_q <= PH_DATA;
          PH_DATA: begin
            sh_q <= sh_q >> 1;
            if (idx_q == last_q) phase_q <= par_on_q ? PH_PAR : PH_STOP;
            else                 idx_q   <= idx_q + 1'b1;
          end
          PH_PAR:  phase_q <= PH_STOP;
          default: phase_q <= PH_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/utx_rts.sv
module utx_rts
  import uart_tx_frac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic ext1x,
  input  logic rts_set,
  input  logic rts_en,
  input  logic cts_en,
  input  logic tx_enable,
  input  logic tx_empty,
  output logic rts
);

  logic [TCNT_W-1:0] cnt_q;
  logic              armed, expire;

  // CTS control takes precedence: both enables set disables auto negation
  assign armed  = rts_en && !cts_en && !tx_enable && tx_empty && rts;
  assign expire = armed && tick16 && (cnt_q == bit_ticks(ext1x) - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rts   <= 1'b0;
    end else begin
      if (!armed)      cnt_q <= '0;
      else if (tick16) cnt_q <= expire ? '0 : cnt_q + 1'b1;
      if (rts_set)     rts <= 1'b1;
      else if (expire) rts <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac
  import uart_tx_frac_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MIN_BITS = 5,
  parameter int unsigned LEN_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              tx_enable,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  char_len,
  input  logic [1:0]        parity_mode,
  input  logic [3:0]        stop_code,
  input  logic              ext1x,
  input  logic              cts_en,
  input  logic              cts,
  input  logic              rts_en,
  input  logic              rts_set,
  output logic              txd,
  output logic              rts,
  output logic              tx_rdy,
  output logic              tx_empty
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              start_evt;
  logic              sh_idle;

  utx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .take      (start_evt),
    .full      (hold_full),
    .data      (hold_data)
  );

  utx_shifter #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16      (tick16),
    .hold_full   (hold_full),
    .hold_data   (hold_data),
    .char_len    (char_len),
    .parity_mode (parity_mode),
    .stop_code   (stop_code),
    .ext1x       (ext1x),
    .cts_en      (cts_en),
    .cts         (cts),
    .take        (start_evt),
    .idle        (sh_idle),
    .txd         (txd)
  );

  assign tx_rdy   = !hold_full;
  assign tx_empty = !hold_full && sh_idle;

  utx_rts u_rts (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .ext1x     (ext1x),
    .rts_set   (rts_set),
    .rts_en    (rts_en),
    .cts_en    (cts_en),
    .tx_enable (tx_enable),
    .tx_empty  (tx_empty),
    .rts       (rts)
  );

endmodule

// File: rtl/uart_tx_frac_chk.sv
module uart_tx_frac_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic rts,
  input logic tx_rdy,
  input logic tx_empty,
  input logic tx_enable,
  input logic cts_en,
  input logic cts,
  input logic rts_en,
  input logic start_evt
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  assert_full_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rdy && !start_evt) |=> !tx_rdy);

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !txd);

  assert_cts_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (!cts_en || cts));

  assert_empty_rdy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_rdy);

  assert_rts_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> $past(tx_empty && !tx_enable));

  assert_rts_kept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rts && (!rts_en || cts_en)) |=> rts);

endmodule

bind uart_tx_frac uart_tx_frac_chk u_chk (.*);

// File: tb/tb_uart_tx_frac.sv
module tb_uart_tx_frac;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       tx_enable = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] char_len = 2'b11;
  logic [1:0] parity_mode = 2'b00;
  logic [3:0] stop_code = 4'd7;
  logic       ext1x = 1'b0;
  logic       cts_en = 1'b0;
  logic       cts = 1'b1;
  logic       rts_en = 1'b0;
  logic       rts_set = 1'b0;
  logic       txd, rts, tx_rdy, tx_empty;

  int    checks = 0;
  int    errors = 0;
  int    busy = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  uart_tx_frac dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_enable(tx_enable),
    .wr_valid(wr_valid), .wr_data(wr_data), .char_len(char_len),
    .parity_mode(parity_mode), .stop_code(stop_code), .ext1x(ext1x),
    .cts_en(cts_en), .cts(cts), .rts_en(rts_en), .rts_set(rts_set),
    .txd(txd), .rts(rts), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
  );

  // ---------------- reference helpers ----------------
  function automatic int stop_ref(input logic [3:0] code, input int nbits, input logic x1);
    if (x1)          return code[3] ? 2 : 1;
    if (code >= 8)   return 17 + int'(code);
    if (nbits == 5)  return 17 + int'(code);
    return 9 + int'(code);
  endfunction

  function automatic int frame_ref();
    int bt, n, p;
    bt = ext1x ? 1 : 16;
    n  = 5 + int'(char_len);
    p  = (parity_mode == 2'b01 || parity_mode == 2'b10) ? 1 : 0;
    return bt * (1 + n + p) + stop_ref(stop_code, n, ext1x);
  endfunction

  // ---------------- behavioural model ----------------
  bit       mq[$];
  bit       m_full;
  bit [7:0] m_data;
  bit       m_rts;
  int       m_rcnt;
  bit       o_full, o_empty, o_rts, m_clear, m_arm;

  task automatic push_frame(input bit [7:0] d);
    int bt, n;
    bit p;
    bt = ext1x ? 1 : 16;
    n  = 5 + int'(char_len);
    p  = 1'b0;
    for (int i = 0; i < bt; i++) mq.push_back(1'b0);
    for (int k = 0; k < n; k++) begin
      p = p ^ d[k];
      for (int i = 0; i < bt; i++) mq.push_back(d[k]);
    end
    if (parity_mode == 2'b01 || parity_mode == 2'b10) begin
      if (parity_mode == 2'b10) p = !p;
      for (int i = 0; i < bt; i++) mq.push_back(p);
    end
    for (int i = 0; i < stop_ref(stop_code, n, ext1x); i++) mq.push_back(1'b1);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_full = 0; m_data = 0; m_rts = 0; m_rcnt = 0;
    end else begin
      o_full  = m_full;
      o_empty = !m_full && (mq.size() == 0);
      o_rts   = m_rts;
      if (tick16) begin
        if (mq.size() != 0) void'(mq.pop_front());
        if (mq.size() == 0 && o_full && (!cts_en || cts)) begin
          push_frame(m_data);
          m_full = 0;
        end
      end
      if (!o_full && wr_valid && tx_enable) begin
        m_full = 1; m_data = wr_data;
      end
      m_arm   = rts_en && !cts_en && !tx_enable && o_empty && o_rts;
      m_clear = 0;
      if (!m_arm) m_rcnt = 0;
      else if (tick16) begin
        if (m_rcnt == (ext1x ? 1 : 16) - 1) begin m_clear = 1; m_rcnt = 0; end
        else m_rcnt++;
      end
      if (rts_set) m_rts = 1;
      else if (m_clear) m_rts = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (outputs come from registers)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "txd",      int'(txd),      (mq.size() != 0) ? int'(mq[0]) : 1);
      chk(cur_req, "rts",      int'(rts),      int'(m_rts));
      chk(cur_req, "tx_rdy",   int'(tx_rdy),   int'(!m_full));
      chk(cur_req, "tx_empty", int'(tx_empty), int'(!m_full && mq.size() == 0));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  int tdiv = 0;
  initial begin
    forever begin
      step();
      tdiv    = (tdiv == 2) ? 0 : tdiv + 1;
      tick16  = (tdiv == 0);
    end
  end

  // busy-span counter: enable pulses seen while tx_empty is low
  initial begin
    forever begin
      @(negedge clk); #2;
      if (tick16 && !tx_empty) busy++;
    end
  end

  task automatic write_char(input logic [7:0] d);
    while (!tx_rdy) step();
    wr_valid = 1'b1; wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic pulse_write(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic wait_empty();
    while (!tx_empty) step();
    step();
  endtask

  task automatic cfg(input logic [1:0] len, input logic [1:0] par,
                     input logic [3:0] code, input logic x1);
    char_len = len; parity_mode = par; stop_code = code; ext1x = x1;
  endtask

  task automatic one_frame(input string req, input logic [7:0] d);
    int exp;
    exp = frame_ref() + 1;
    busy = 0;
    write_char(d);
    wait_empty();
    chk(req, "frame span in pulses", busy, exp);
  endtask

  task automatic pulse_rts_set();
    rts_set = 1'b1; step(); rts_set = 1'b0; step();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    int n_low, cnt, exp;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    cur_req = "R1";
    chk("R1", "txd after reset", int'(txd), 1);
    chk("R1", "rts after reset", int'(rts), 0);
    chk("R1", "tx_rdy after reset", int'(tx_rdy), 1);
    chk("R1", "tx_empty after reset", int'(tx_empty), 1);

    // R3 and R5: 8-bit frames, stop codes across both halves
    cur_req = "R5";
    cfg(2'b11, 2'b00, 4'd0,  1'b0); one_frame("R5", 8'hA5);
    cfg(2'b11, 2'b00, 4'd7,  1'b0); one_frame("R3", 8'h3C);
    cfg(2'b11, 2'b00, 4'd8,  1'b0); one_frame("R5", 8'h81);
    cfg(2'b10, 2'b00, 4'd15, 1'b0); one_frame("R5", 8'h7E);

    // R4 parity modes
    cur_req = "R4";
    cfg(2'b10, 2'b01, 4'd3, 1'b0); one_frame("R4", 8'h53);
    cfg(2'b10, 2'b10, 4'd3, 1'b0); one_frame("R4", 8'h53);
    cfg(2'b01, 2'b10, 4'd9, 1'b0); one_frame("R4", 8'hC0);
    cfg(2'b01, 2'b11, 4'd2, 1'b0); one_frame("R4", 8'h2D);

    // R6 five-bit characters
    cur_req = "R6";
    cfg(2'b00, 2'b00, 4'd0,  1'b0); one_frame("R6", 8'hF5);
    cfg(2'b00, 2'b01, 4'd7,  1'b0); one_frame("R6", 8'h0B);
    cfg(2'b00, 2'b00, 4'd15, 1'b0); one_frame("R6", 8'h16);

    // R7 bit-rate enable
    cur_req = "R7";
    cfg(2'b11, 2'b01, 4'd7, 1'b1); one_frame("R7", 8'h96);
    cfg(2'b11, 2'b00, 4'd8, 1'b1); one_frame("R7", 8'h69);

    // R2: write while disabled is ignored
    cur_req = "R2";
    cfg(2'b11, 2'b00, 4'd7, 1'b0);
    tx_enable = 1'b0;
    pulse_write(8'h11);
    repeat (60) step();
    chk("R2", "tx_rdy after disabled write", int'(tx_rdy), 1);
    chk("R2", "tx_empty after disabled write", int'(tx_empty), 1);
    tx_enable = 1'b1;

    // R8 back to back with an extra write while full (R2)
    cur_req = "R8";
    exp  = 2 * frame_ref() + 1;
    busy = 0;
    write_char(8'h5A);
    write_char(8'hC3);
    pulse_write(8'hFF);
    chk("R2", "tx_rdy while holding full", int'(tx_rdy), 0);
    chk("R11", "tx_empty while busy", int'(tx_empty), 0);
    wait_empty();
    chk("R8", "two-frame span in pulses", busy, exp);

    // R9 CTS gating of start
    cur_req = "R9";
    cts_en = 1'b1; cts = 1'b0;
    write_char(8'h0F);
    n_low = 0;
    for (int i = 0; i < 150; i++) begin
      step();
      if (!txd) n_low++;
    end
    chk("R9", "low samples while cts negated", n_low, 0);
    chk("R9", "tx_rdy while cts negated", int'(tx_rdy), 0);
    exp  = frame_ref() + 1;
    busy = 0;
    cts  = 1'b1;
    wait_empty();
    chk("R9", "span after cts asserted", busy, exp);

    // R10 CTS dropped mid-character
    cur_req = "R10";
    exp  = frame_ref() + 1;
    busy = 0;
    write_char(8'hE1);
    repeat (90) step();
    cts = 1'b0;
    wait_empty();
    chk("R10", "span with cts dropped mid-frame", busy, exp);
    cts = 1'b1; cts_en = 1'b0;

    // R12 automatic RTS negation
    cur_req = "R12";
    rts_en = 1'b1;
    pulse_rts_set();
    chk("R12", "rts after set", int'(rts), 1);
    write_char(8'h44);
    tx_enable = 1'b0;
    while (!tx_empty) step();
    cnt = 0;
    while (rts && cnt < 100) begin
      if (tick16) cnt++;
      step();
    end
    chk("R12", "pulses from empty to rts low", cnt, 16);

    // R13 RTS kept when control off or overridden by CTS control
    cur_req = "R13";
    rts_en = 1'b0;
    pulse_rts_set();
    repeat (90) step();
    chk("R13", "rts with rts_en clear", int'(rts), 1);
    rts_en = 1'b1; cts_en = 1'b1;
    repeat (90) step();
    chk("R13", "rts with both enables", int'(rts), 1);
    cur_req = "R12";
    cts_en = 1'b0;
    repeat (70) step();
    chk("R12", "rts after cts_en cleared", int'(rts), 0);
    tx_enable = 1'b1; rts_en = 1'b0;

    // R11 status during a frame
    cur_req = "R11";
    write_char(8'h99);
    repeat (10) step();
    chk("R11", "tx_rdy after hand-over", int'(tx_rdy), 1);
    chk("R11", "tx_empty during frame", int'(tx_empty), 0);
    wait_empty();
    chk("R11", "tx_empty after frame", int'(tx_empty), 1);

    repeat (5) step();
    finish_run();
  end

endmodule